// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital controller in front of a successive-approximation converter core. Software programs it through a small write-only register port: a mode register (comparator enable, trigger source, single or continuous operation, conversion time, start bit) and a channel register. The block decides when a conversion begins, either on a software start or on a pulse from a timer. It holds the channel steady towards the analog core for the length of the conversion, and at the end it captures the core's output into a result register and raises a one-cycle completion interrupt.

The analog core sees three things. A one-cycle `conv_start` pulse marks the first cycle of every conversion, including a restart. `busy` is high while a conversion is in progress. `core_chan` gives the channel being converted. The core presents its answer on `core_data`, and the block samples it in the last cycle of the conversion. The result is a held register, not a stream, so it has no valid/ready handshake and cannot be back-pressured. `irq_done` marks each new value, and the value stays put until the next successful conversion.

A whole-block enable input gates everything. While it is low, the block sits in its reset state, and all writes and triggers are lost.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `blk_en` is 0, every register is held at reset: `busy`, `conv_start`, `irq_done`, `core_chan` and `result` read 0, and writes and timer pulses are discarded. Dropping `blk_en` in the middle of a conversion abandons it.
- R2: In software trigger mode, a write to the mode register (`wr_addr`=0) with start bit 7 and comparator enable bit 0 set, and trigger bit 1 clear, starts a conversion while idle. In the following cycle `busy` and `conv_start` are 1 and `core_chan` equals the channel register (`wr_addr`=1, bits 3:0).
- R3: In timer trigger mode (mode bit 1 set) with bit 0 set, a `timer_trig` pulse while idle starts a conversion in the next cycle. A pulse in software mode, or while a conversion is running, is ignored.
- R4: Mode bits 5:3 select the conversion length: 0..7 give 16, 24, 32, 48, 64, 96, 128 and 192 cycles. `irq_done` is high for exactly one cycle, that many cycles after the cycle in which `conv_start` was high.
- R5: In single mode (mode bit 2 clear), `busy` is 0 in the cycle in which `irq_done` is 1, and it stays 0 until the next trigger.
- R6: In continuous mode (mode bit 2 set), the cycle that carries `irq_done` also carries `conv_start`. The new conversion uses the current channel register and the current length field.
- R7: Except in timer-triggered single mode, a channel write during a conversion aborts it. In the next cycle `conv_start` pulses, `core_chan` shows the new channel and the full length restarts. The aborted conversion gives no interrupt.
- R8: In timer-triggered single mode, a channel write during a conversion leaves `core_chan` and the timing unchanged. The new channel appears only when the next conversion starts.
- R9: `result` takes the value `core_data` had in the last cycle of a completed conversion, and it changes at no other time while enabled.
- R10: A mode write while busy with bit 7 or bit 0 clear abandons the conversion. `busy` drops in the next cycle, and no interrupt and no result update follow.
- R11: A mode write with the start bit set is ignored when bit 0 is clear or bit 1 (timer trigger) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en | input | 1 | Block enable; low holds reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = mode register, 1 = channel register |
| wr_data | input | 8 | Write data |
| timer_trig | input | 1 | Timer trigger pulse |
| core_data | input | RES_W | Conversion value from the analog core |
| core_chan | output | CHAN_W | Channel being converted |
| conv_start | output | 1 | First cycle of a conversion |
| busy | output | 1 | Conversion in progress (start bit) |
| irq_done | output | 1 | One-cycle completion interrupt |
| result | output | RES_W | Last completed conversion value |

## Verification
The assertions assume that `timer_trig` never coincides with a mode write. They also assume that software does not change the trigger or continuous bits while a conversion runs, because either act would make the first-cycle decisions ambiguous. The stimulus therefore changes mode only while idle, apart from deliberate stop writes. It spaces every trigger away from register writes. It drives `core_data` with a new value each cycle, so that a result latched one cycle early or late shows up as a mismatch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int DATA_W = 8;
  localparam int TSEL_W = 3;
  localparam int LEN_W  = 8;

  // Mode register field positions (software-visible encoding)
  localparam int M_CMP   = 0;
  localparam int M_TRIG  = 1;
  localparam int M_CONT  = 2;
  localparam int M_TSEL  = 3;
  localparam int M_START = 7;

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_CHAN = 1'b1;

  typedef struct packed {
    logic              cmp_en;
    logic              trig_tmr;
    logic              cont;
    logic [TSEL_W-1:0] tsel;
  } cfg_t;

  // Length = {2,3}[sel[0]] << (3 + sel[2:1])  -> 16,24,32,48,64,96,128,192
  function automatic logic [LEN_W-1:0] conv_len(input logic [TSEL_W-1:0] sel);
    logic [LEN_W-1:0] base;
    base = sel[0] ? LEN_W'(3) : LEN_W'(2);
    return base << (3 + int'(sel[2:1]));
  endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  blk_en,
  input  logic                  wr_en,
  input  logic                  wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output cfg_t                  cfg,
  output logic [CHAN_W-1:0]     chan_reg,
  output logic                  mode_wr,
  output logic                  chan_wr
);

  assign mode_wr = blk_en && wr_en && (wr_addr == ADDR_MODE);
  assign chan_wr = blk_en && wr_en && (wr_addr == ADDR_CHAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      chan_reg <= '0;
    end else if (!blk_en) begin
      cfg      <= '0;
      chan_reg <= '0;
    end else begin
      if (mode_wr) begin
        cfg.cmp_en   <= wr_data[M_CMP];
        cfg.trig_tmr <= wr_data[M_TRIG];
        cfg.cont     <= wr_data[M_CONT];
        cfg.tsel     <= wr_data[M_TSEL +: TSEL_W];
      end
      if (chan_wr) chan_reg <= wr_data[CHAN_W-1:0];
    end
  end

endmodule

// File: rtl/adc_seq_cnt.sv
module adc_seq_cnt
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_en,
  input  logic             load,
  input  logic             run,
  input  logic [LEN_W-1:0] len,
  output logic             last
);

  logic [LEN_W-1:0] cnt;

  assign last = run && (cnt == len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!blk_en || load)  cnt <= '0;
    else if (run)              cnt <= cnt + LEN_W'(1);
  end

endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  cfg_t              cfg,
  input  logic [CHAN_W-1:0] chan_reg,
  input  logic              mode_wr,
  input  logic              chan_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              timer_trig,
  output logic              busy,
  output logic              conv_start,
  output logic [CHAN_W-1:0] cur_chan,
  output logic              cmplt
);

  logic             stop, restart, sw_go, tm_go, next_seq, load, cnt_last;
  logic [LEN_W-1:0] cur_len;
  logic             defer_chan;

  // Timer-triggered single mode keeps the running channel on a channel write
  assign defer_chan = cfg.trig_tmr && !cfg.cont;

  assign stop     = mode_wr && busy && !(wr_data[M_START] && wr_data[M_CMP]);
  assign restart  = chan_wr && busy && !stop && !defer_chan;
  assign cmplt    = cnt_last && !stop && !restart;
  assign next_seq = cmplt && cfg.cont;
  assign sw_go    = mode_wr && !busy && wr_data[M_START] && wr_data[M_CMP]
                    && !wr_data[M_TRIG];
  assign tm_go    = timer_trig && !busy && cfg.trig_tmr && cfg.cmp_en;
  assign load     = restart || next_seq || sw_go || tm_go;

  adc_seq_cnt cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .blk_en (blk_en),
    .load   (load),
    .run    (busy),
    .len    (cur_len),
    .last   (cnt_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      cur_chan   <= '0;
      cur_len    <= '0;
    end else if (!blk_en) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      cur_chan   <= '0;
      cur_len    <= '0;
    end else begin
      conv_start <= load;
      if (stop)                       busy <= 1'b0;
      else if (cmplt && !cfg.cont)    busy <= 1'b0;
      else if (sw_go || tm_go)        busy <= 1'b1;

      if (restart)                             cur_chan <= wr_data[CHAN_W-1:0];
      else if (next_seq || sw_go || tm_go)     cur_chan <= chan_reg;

      if (sw_go)                  cur_len <= conv_len(wr_data[M_TSEL +: TSEL_W]);
      else if (next_seq || tm_go) cur_len <= conv_len(cfg.tsel);
    end
  end

endmodule

// File: rtl/adc_seq_res.sv
module adc_seq_res #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_en,
  input  logic             cmplt,
  input  logic [RES_W-1:0] core_data,
  output logic [RES_W-1:0] result,
  output logic             irq_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      irq_done <= 1'b0;
    end else if (!blk_en) begin
      result   <= '0;
      irq_done <= 1'b0;
    end else begin
      irq_done <= cmplt;
      if (cmplt) result <= core_data;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              timer_trig,
  input  logic [RES_W-1:0]  core_data,
  output logic [CHAN_W-1:0] core_chan,
  output logic              conv_start,
  output logic              busy,
  output logic              irq_done,
  output logic [RES_W-1:0]  result
);

  cfg_t              cfg;
  logic [CHAN_W-1:0] chan_reg;
  logic              mode_wr, chan_wr, cmplt;

  adc_seq_cfg #(.CHAN_W(CHAN_W)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_en   (blk_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cfg      (cfg),
    .chan_reg (chan_reg),
    .mode_wr  (mode_wr),
    .chan_wr  (chan_wr)
  );

  adc_seq_ctl #(.CHAN_W(CHAN_W)) ctl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_en     (blk_en),
    .cfg        (cfg),
    .chan_reg   (chan_reg),
    .mode_wr    (mode_wr),
    .chan_wr    (chan_wr),
    .wr_data    (wr_data),
    .timer_trig (timer_trig),
    .busy       (busy),
    .conv_start (conv_start),
    .cur_chan   (core_chan),
    .cmplt      (cmplt)
  );

  adc_seq_res #(.RES_W(RES_W)) res_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_en    (blk_en),
    .cmplt     (cmplt),
    .core_data (core_data),
    .result    (result),
    .irq_done  (irq_done)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CHAN_W = 4,
  parameter int RES_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_en,
  input logic [CHAN_W-1:0] core_chan,
  input logic              conv_start,
  input logic              busy,
  input logic              irq_done,
  input logic [RES_W-1:0]  result
);

  // R1
  blk_off_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(blk_en) |-> (!busy && !conv_start && !irq_done && result == '0));

  // R4
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n || !blk_en)
    irq_done |=> !irq_done);

  // R4
  irq_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || !blk_en)
    irq_done |-> $past(busy));

  // R2
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || !blk_en)
    conv_start |-> busy);

  // R8
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !blk_en)
    (busy && !conv_start) |-> $stable(core_chan));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !blk_en)
    ($past(blk_en) && !irq_done) |-> $stable(result));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.CHAN_W(CHAN_W), .RES_W(RES_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .blk_en     (blk_en),
  .core_chan  (core_chan),
  .conv_start (conv_start),
  .busy       (busy),
  .irq_done   (irq_done),
  .result     (result)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

  localparam int CW = 4;
  localparam int RW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          blk_en = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_addr = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          timer_trig = 1'b0;
  logic [RW-1:0] core_data = '0;
  logic [CW-1:0] core_chan;
  logic          conv_start, busy, irq_done;
  logic [RW-1:0] result;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  adc_seq_ctrl #(.CHAN_W(CW), .RES_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .timer_trig(timer_trig), .core_data(core_data),
    .core_chan(core_chan), .conv_start(conv_start), .busy(busy),
    .irq_done(irq_done), .result(result)
  );

  // core output changes every cycle
  always @(negedge clk) begin
    cyc <= cyc + 1;
    core_data <= RW'((cyc * 149 + 7) % 4096);
  end

  // ---------------- behavioural reference model ----------------
  int m_busy, m_cs, m_irq, m_chan, m_res;
  int m_cnt, m_len;
  int r_cmp, r_trig, r_cont, r_tsel, r_chan;

  function automatic int len_of(input int sel);
    case (sel)
      0: return 16;  1: return 24;  2: return 32;  3: return 48;
      4: return 64;  5: return 96;  6: return 128; default: return 192;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !blk_en) begin
      m_busy = 0; m_cs = 0; m_irq = 0; m_chan = 0; m_res = 0; m_cnt = 0; m_len = 0;
      r_cmp = 0; r_trig = 0; r_cont = 0; r_tsel = 0; r_chan = 0;
    end else begin
      bit mw, cw, st, go;
      mw = wr_en && !wr_addr;
      cw = wr_en && wr_addr;
      m_irq = 0; m_cs = 0;
      if (mw && m_busy != 0 && !(wr_data[7] && wr_data[0])) begin
        m_busy = 0;
      end else if (cw && m_busy != 0 && !(r_trig != 0 && r_cont == 0)) begin
        m_chan = int'(wr_data[3:0]); m_cnt = 0; m_cs = 1;
      end else if (m_busy != 0 && m_cnt == m_len - 1) begin
        m_res = int'(core_data); m_irq = 1;
        if (r_cont != 0) begin
          m_cnt = 0; m_chan = r_chan; m_len = len_of(r_tsel); m_cs = 1;
        end else m_busy = 0;
      end else if (m_busy == 0) begin
        st = mw && wr_data[7] && wr_data[0] && !wr_data[1];
        go = timer_trig && r_trig != 0 && r_cmp != 0;
        if (st || go) begin
          m_busy = 1; m_cnt = 0; m_chan = r_chan; m_cs = 1;
          m_len = st ? len_of(int'(wr_data[5:3])) : len_of(r_tsel);
        end
      end else m_cnt++;
      if (mw) begin
        r_cmp = int'(wr_data[0]); r_trig = int'(wr_data[1]);
        r_cont = int'(wr_data[2]); r_tsel = int'(wr_data[5:3]);
      end
      if (cw) r_chan = int'(wr_data[3:0]);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(busy) == m_busy,       "R5 busy",       int'(busy), m_busy);
      chk(int'(conv_start) == m_cs,   "R2 conv_start", int'(conv_start), m_cs);
      chk(int'(irq_done) == m_irq,    "R4 irq_done",   int'(irq_done), m_irq);
      chk(int'(core_chan) == m_chan,  "R7 core_chan",  int'(core_chan), m_chan);
      chk(int'(result) == m_res,      "R9 result",     int'(result), m_res);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic trig();
    @(negedge clk); timer_trig = 1'b1;
    @(negedge clk); timer_trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles from the conv_start cycle to the irq cycle
  task automatic measure(output int n);
    n = 0;
    while (!conv_start) @(negedge clk);
    do begin @(negedge clk); n++; end while (!irq_done && n < 400);
  endtask

  function automatic logic [7:0] mode(input bit start, input bit cmp, input bit tmr,
                                      input bit cont, input int tsel);
    return {start, 1'b0, 3'(tsel), cont, tmr, cmp};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, r0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state and disabled writes
    chk(busy == 0 && result == 0 && irq_done == 0, "R1 reset", int'(busy), 0);
    wr(1'b0, mode(1, 1, 0, 0, 0));
    chk(busy == 0, "R1 write while disabled", int'(busy), 0);
    blk_en = 1'b1;
    idle(2);

    // R2/R4/R5: software single, shortest length
    wr(1'b1, 8'd5);
    wr(1'b0, mode(1, 1, 0, 0, 0));
    chk(busy == 1 && core_chan == 5, "R2 sw start", int'(core_chan), 5);
    measure(n);
    chk(n == 16, "R4 len sel0", n, 16);
    chk(busy == 0, "R5 single idle", int'(busy), 0);
    idle(3);

    // R4: longest length
    wr(1'b0, mode(1, 1, 0, 0, 7));
    measure(n);
    chk(n == 192, "R4 len sel7", n, 192);
    idle(3);

    // R11: ignored starts
    wr(1'b0, mode(1, 0, 0, 0, 0));
    chk(busy == 0, "R11 cmp off", int'(busy), 0);
    wr(1'b0, mode(1, 1, 1, 0, 0));
    chk(busy == 0, "R11 start in timer mode", int'(busy), 0);
    // R3: trigger in software mode ignored
    wr(1'b0, mode(0, 1, 0, 0, 0));
    trig();
    chk(busy == 0, "R3 trig in sw mode", int'(busy), 0);

    // R6/R7/R10: software continuous, length 24
    wr(1'b0, mode(1, 1, 0, 1, 1));
    idle(10);
    wr(1'b1, 8'd9);
    chk(conv_start == 1 && core_chan == 9, "R7 restart", int'(core_chan), 9);
    measure(n);
    chk(n == 24, "R7 full length after restart", n, 24);
    chk(conv_start == 1, "R6 back to back", int'(conv_start), 1);
    measure(n);
    chk(n == 24, "R6 continuous period", n, 24);
    idle(5);
    r0 = int'(result);
    wr(1'b0, mode(0, 1, 0, 1, 1));
    chk(busy == 0, "R10 stop", int'(busy), 0);
    n = 0;
    repeat (40) begin @(negedge clk); if (irq_done) n++; end
    chk(n == 0, "R10 no irq after stop", n, 0);
    chk(int'(result) == r0, "R9 result held", int'(result), r0);

    // R3/R8: timer single
    wr(1'b0, mode(0, 1, 1, 0, 0));
    wr(1'b1, 8'd3);
    trig();
    chk(busy == 1 && core_chan == 3, "R3 timer start", int'(core_chan), 3);
    idle(3);
    trig();
    idle(2);
    wr(1'b1, 8'd12);
    chk(conv_start == 0 && core_chan == 3, "R8 channel held", int'(core_chan), 3);
    while (!irq_done) @(negedge clk);
    chk(busy == 0, "R5 timer single idle", int'(busy), 0);
    idle(3);
    trig();
    chk(core_chan == 12, "R8 new channel on next start", int'(core_chan), 12);
    while (!irq_done) @(negedge clk);
    idle(3);

    // R7: timer continuous restart, then R1: disable mid conversion
    wr(1'b0, mode(0, 1, 1, 1, 2));
    trig();
    idle(5);
    wr(1'b1, 8'd1);
    chk(conv_start == 1 && core_chan == 1, "R7 timer cont restart", int'(core_chan), 1);
    idle(6);
    blk_en = 1'b0;
    idle(1);
    chk(busy == 0 && result == 0, "R1 disable aborts", int'(busy), 0);
    trig();
    chk(busy == 0, "R1 trig while disabled", int'(busy), 0);
    idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule